// File: doc/BRIEF.md
# PCI Bridge Forwarding Address Decoder

This block decides, for each transaction seen on either side of a PCI-to-PCI bridge, whether the bridge claims it and passes it across. Three programmable address windows are compared against the transaction address: one for I/O, one for non-prefetchable memory and one for prefetchable memory. The legacy display ranges are folded into the same decision: the frame buffer, the register ports and the palette ports. Primary-side (downstream) traffic is claimed when it hits a window or an enabled legacy range. Secondary-side (upstream) traffic is claimed only when it misses all of them.

The configuration inputs (window bounds, command enables, bridge-control bits) are captured into a register stage every clock. A change on them governs transactions presented from the next clock onward. Each transaction is presented for one cycle with a valid strobe. Its decision appears on registered outputs one clock later, together with a separate flag that marks palette writes for snooping.

Top module: `pbd_fwd_decoder`

## Requirements
- R1: While reset is asserted, and afterwards whenever no transaction was presented in the previous cycle, `valid_o`, `fwd_o` and `snoop_o` are low.
- R2: A transaction presented with `txn_valid_i` high at clock edge k produces its result on the outputs after edge k+1. The decision uses the configuration inputs that were present at edge k-1 or earlier. A configuration change made in the same cycle as a transaction does not affect that transaction.
- R3: A memory window holds 1 MB frames. It covers addresses from `base`×2^20 through `limit`×2^20 + 0xFFFFF inclusive. A window whose limit frame is all ones covers the last byte of the 64-bit space. A window with limit below base covers nothing.
- R4: The I/O window holds 4 KB frames on the low 16 address bits. It covers `io_base`×0x1000 through `io_limit`×0x1000 + 0xFFF. Address bits 63:16 of an I/O access are ignored.
- R5: With `io_en_i` low, no I/O access is forwarded or snooped in either direction. With `mem_en_i` low, no memory access is forwarded in either direction.
- R6: A primary-side access (`txn_sec_i`=0) is forwarded when it falls inside any enabled window or enabled legacy display range.
- R7: A secondary-side access (`txn_sec_i`=1) is forwarded when its space is enabled and it falls outside every window and every enabled legacy display range. Legacy display accesses from the secondary side are therefore blocked.
- R8: With `vga_en_i` set, memory addresses 0xA0000 through 0xBFFFF count as a claimed range.
- R9: With `vga_en_i` set, I/O accesses count as a claimed range when address bits 9:0 lie in 0x3B0–0x3BB or 0x3C0–0x3DF. Bits 15:10 are ignored, so every alias matches.
- R10: With `vga_dec16_i` set, the legacy I/O and palette matches also require address bits 15:10 to be zero.
- R11: With `pal_snoop_i` set, a primary-side I/O access whose bits 9:0 equal 0x3C6, 0x3C8 or 0x3C9 raises `snoop_o`. The R10 alias rule applies. The flag is independent of `fwd_o`, so both can be high together.
- R12: Overlapping windows and legacy ranges need no priority: a hit in any of them gives the same single forward result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txn_valid_i | input | 1 | Transaction present this cycle |
| txn_sec_i | input | 1 | 1: arrived on secondary side, 0: primary side |
| txn_io_i | input | 1 | 1: I/O space, 0: memory space |
| txn_addr_i | input | 64 | Transaction address |
| io_base_i | input | 4 | I/O window base, 4 KB frame number |
| io_limit_i | input | 4 | I/O window limit, 4 KB frame number |
| mem_base_i | input | 44 | Non-prefetchable window base, 1 MB frame number |
| mem_limit_i | input | 44 | Non-prefetchable window limit, 1 MB frame number |
| pref_base_i | input | 44 | Prefetchable window base, 1 MB frame number |
| pref_limit_i | input | 44 | Prefetchable window limit, 1 MB frame number |
| io_en_i | input | 1 | I/O space decode enable |
| mem_en_i | input | 1 | Memory space decode enable |
| vga_en_i | input | 1 | Legacy display range enable |
| vga_dec16_i | input | 1 | Full 16-bit decode of legacy I/O addresses |
| pal_snoop_i | input | 1 | Palette snoop enable |
| valid_o | output | 1 | Result valid |
| fwd_o | output | 1 | Transaction is claimed and forwarded |
| snoop_o | output | 1 | Transaction is a palette access to snoop |

## Verification
The forward decision and the palette snoop flag can be raised in the same cycle. This happens for a primary-side I/O access to 0x3C8 with both the legacy display enable and the palette snoop enable set. The bench provokes it, and also the snoop-only case with the legacy ranges off. The second function that can land in the same cycle is a configuration change arriving together with a transaction. The bench changes an enable in the very cycle a hitting address is presented, and expects the old setting to decide. A behavioural reference model, built from byte-range arithmetic, predicts all three outputs for every clock and is compared each cycle.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  typedef struct packed {
    logic io_en;
    logic mem_en;
    logic vga_en;
    logic vga_dec16;
    logic pal_snoop;
  } pbd_ctl_t;

  localparam int unsigned ISA_W = 10;
endpackage

// File: rtl/pbd_window.sv
module pbd_window #(
  parameter int unsigned AW   = 64,
  parameter int unsigned GRAN = 20
) (
  input  logic               en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [AW-GRAN-1:0] base_i,
  input  logic [AW-GRAN-1:0] limit_i,
  output logic               hit_o
);
  localparam int unsigned FW = AW - GRAN;

  // compare frame numbers only: no carry out of the top frame
  logic [FW-1:0] frame;
  assign frame = addr_i[AW-1:GRAN];
  assign hit_o = en_i && (frame >= base_i) && (frame <= limit_i);

  always_comb begin
    if (en_i && (limit_i < base_i)) begin
      AST_EMPTY_WIN: assert (!hit_o); // R3
    end
  end
endmodule

// File: rtl/pbd_vga.sv
module pbd_vga
  import pbd_pkg::*;
#(
  parameter int unsigned AW    = 64,
  parameter int unsigned IO_AW = 16
) (
  input  logic          is_io_i,
  input  logic [AW-1:0] addr_i,
  input  pbd_ctl_t      ctl_i,
  output logic          vga_hit_o,
  output logic          pal_hit_o
);
  localparam logic [AW-1:0] FB_LO = AW'('h0A_0000);
  localparam logic [AW-1:0] FB_HI = AW'('h0B_FFFF);

  logic [ISA_W-1:0] low;
  logic             alias_ok;
  logic             io_rng;
  logic             pal_rng;
  logic             fb_rng;

  assign low      = addr_i[ISA_W-1:0];
  assign alias_ok = !ctl_i.vga_dec16 || (addr_i[IO_AW-1:ISA_W] == '0);
  assign io_rng   = ((low >= 10'h3B0) && (low <= 10'h3BB)) ||
                    ((low >= 10'h3C0) && (low <= 10'h3DF));
  assign pal_rng  = (low == 10'h3C6) || (low == 10'h3C8) || (low == 10'h3C9);
  assign fb_rng   = (addr_i >= FB_LO) && (addr_i <= FB_HI);

  always_comb begin
    vga_hit_o = 1'b0;
    if (ctl_i.vga_en) begin
      if (is_io_i) vga_hit_o = ctl_i.io_en && io_rng && alias_ok;
      else         vga_hit_o = ctl_i.mem_en && fb_rng;
    end
  end

  assign pal_hit_o = is_io_i && ctl_i.io_en && ctl_i.pal_snoop && pal_rng && alias_ok;

  always_comb begin
    if (pal_hit_o) begin
      AST_PAL_SUBSET: assert (io_rng && alias_ok); // R11
    end
  end
endmodule

// File: rtl/pbd_fwd_decoder.sv
module pbd_fwd_decoder
  import pbd_pkg::*;
#(
  parameter int unsigned MEM_AW   = 64,
  parameter int unsigned MEM_GRAN = 20,
  parameter int unsigned IO_AW    = 16,
  parameter int unsigned IO_GRAN  = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       txn_valid_i,
  input  logic                       txn_sec_i,
  input  logic                       txn_io_i,
  input  logic [MEM_AW-1:0]          txn_addr_i,
  input  logic [IO_AW-IO_GRAN-1:0]   io_base_i,
  input  logic [IO_AW-IO_GRAN-1:0]   io_limit_i,
  input  logic [MEM_AW-MEM_GRAN-1:0] mem_base_i,
  input  logic [MEM_AW-MEM_GRAN-1:0] mem_limit_i,
  input  logic [MEM_AW-MEM_GRAN-1:0] pref_base_i,
  input  logic [MEM_AW-MEM_GRAN-1:0] pref_limit_i,
  input  logic                       io_en_i,
  input  logic                       mem_en_i,
  input  logic                       vga_en_i,
  input  logic                       vga_dec16_i,
  input  logic                       pal_snoop_i,
  output logic                       valid_o,
  output logic                       fwd_o,
  output logic                       snoop_o
);
  localparam int unsigned MEM_FW = MEM_AW - MEM_GRAN;
  localparam int unsigned IO_FW  = IO_AW - IO_GRAN;

  // configuration register stage
  pbd_ctl_t          ctl_q;
  logic [IO_FW-1:0]  io_base_q, io_limit_q;
  logic [MEM_FW-1:0] mem_base_q, mem_limit_q, pref_base_q, pref_limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q        <= '0;
      io_base_q    <= '0;
      io_limit_q   <= '0;
      mem_base_q   <= '0;
      mem_limit_q  <= '0;
      pref_base_q  <= '0;
      pref_limit_q <= '0;
    end else begin
      ctl_q        <= '{io_en: io_en_i, mem_en: mem_en_i, vga_en: vga_en_i,
                        vga_dec16: vga_dec16_i, pal_snoop: pal_snoop_i};
      io_base_q    <= io_base_i;
      io_limit_q   <= io_limit_i;
      mem_base_q   <= mem_base_i;
      mem_limit_q  <= mem_limit_i;
      pref_base_q  <= pref_base_i;
      pref_limit_q <= pref_limit_i;
    end
  end

  logic io_win_en, mem_win_en;
  logic io_hit, mem_hit, pref_hit;
  logic vga_hit, pal_hit;
  logic win_hit, claim, space_en;
  logic fwd_d, snoop_d;

  assign io_win_en  = txn_io_i && ctl_q.io_en;
  assign mem_win_en = !txn_io_i && ctl_q.mem_en;

  pbd_window #(.AW(IO_AW), .GRAN(IO_GRAN)) u_io_win (
    .en_i   (io_win_en),
    .addr_i (txn_addr_i[IO_AW-1:0]),
    .base_i (io_base_q),
    .limit_i(io_limit_q),
    .hit_o  (io_hit)
  );

  pbd_window #(.AW(MEM_AW), .GRAN(MEM_GRAN)) u_mem_win (
    .en_i   (mem_win_en),
    .addr_i (txn_addr_i),
    .base_i (mem_base_q),
    .limit_i(mem_limit_q),
    .hit_o  (mem_hit)
  );

  pbd_window #(.AW(MEM_AW), .GRAN(MEM_GRAN)) u_pref_win (
    .en_i   (mem_win_en),
    .addr_i (txn_addr_i),
    .base_i (pref_base_q),
    .limit_i(pref_limit_q),
    .hit_o  (pref_hit)
  );

  pbd_vga #(.AW(MEM_AW), .IO_AW(IO_AW)) u_vga (
    .is_io_i  (txn_io_i),
    .addr_i   (txn_addr_i),
    .ctl_i    (ctl_q),
    .vga_hit_o(vga_hit),
    .pal_hit_o(pal_hit)
  );

  assign win_hit  = io_hit | mem_hit | pref_hit;
  assign claim    = win_hit | vga_hit;
  assign space_en = txn_io_i ? ctl_q.io_en : ctl_q.mem_en;
  assign fwd_d    = txn_valid_i && (txn_sec_i ? (space_en && !claim) : claim);
  assign snoop_d  = txn_valid_i && !txn_sec_i && pal_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      fwd_o   <= 1'b0;
      snoop_o <= 1'b0;
    end else begin
      valid_o <= txn_valid_i;
      fwd_o   <= fwd_d;
      snoop_o <= snoop_d;
    end
  end

  AST_SNOOP_PRI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_o |-> $past(!txn_sec_i && txn_io_i)); // R11

  AST_IO_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(txn_io_i && !ctl_q.io_en)) |-> (!fwd_o && !snoop_o)); // R5

  AST_VGA_UP_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(txn_sec_i && vga_hit)) |-> !fwd_o); // R7

  AST_DOWN_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(!txn_sec_i && (vga_hit || win_hit))) |-> fwd_o); // R6
endmodule

// File: tb/pbd_fwd_decoder_tb.sv
module pbd_fwd_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        t_valid = 1'b0, t_sec = 1'b0, t_io = 1'b0;
  logic [63:0] t_addr = '0;
  logic [3:0]  io_base = '0, io_limit = '0;
  logic [43:0] mem_base = '0, mem_limit = '0, pref_base = '0, pref_limit = '0;
  logic        io_en = 1'b0, mem_en = 1'b0, vga_en = 1'b0, vga_dec16 = 1'b0, pal_snoop = 1'b0;
  logic        valid_o, fwd_o, snoop_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbd_fwd_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .txn_valid_i(t_valid), .txn_sec_i(t_sec), .txn_io_i(t_io), .txn_addr_i(t_addr),
    .io_base_i(io_base), .io_limit_i(io_limit),
    .mem_base_i(mem_base), .mem_limit_i(mem_limit),
    .pref_base_i(pref_base), .pref_limit_i(pref_limit),
    .io_en_i(io_en), .mem_en_i(mem_en), .vga_en_i(vga_en),
    .vga_dec16_i(vga_dec16), .pal_snoop_i(pal_snoop),
    .valid_o(valid_o), .fwd_o(fwd_o), .snoop_o(snoop_o)
  );

  // reference model state: configuration as seen by the decoder
  logic [3:0]  m_iob, m_iol;
  logic [43:0] m_mb, m_ml, m_pb, m_pl;
  bit m_ioen, m_memen, m_vga, m_d16, m_pal;
  bit e_valid, e_fwd, e_snoop;
  string cur_tag = "R1";
  string e_tag = "R1";
  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit started = 0, done = 0;

  function automatic void predict(input bit v, input bit sec, input bit io,
                                  input logic [63:0] a,
                                  output bit ev, output bit ef, output bit es);
    logic [63:0] lo, hi;
    logic [15:0] a16;
    logic [9:0]  l10;
    bit in_mem, in_pref, in_io, fb, vio, pal, alias_ok, win, leg, sp;
    lo = {m_mb, 20'h0};  hi = {m_ml, 20'hFFFFF};  in_mem  = (a >= lo) && (a <= hi);
    lo = {m_pb, 20'h0};  hi = {m_pl, 20'hFFFFF};  in_pref = (a >= lo) && (a <= hi);
    a16 = a[15:0];
    in_io = (a16 >= {m_iob, 12'h000}) && (a16 <= {m_iol, 12'hFFF});
    fb  = (a >= 64'hA0000) && (a <= 64'hBFFFF);
    l10 = a[9:0];
    vio = (l10 inside {[10'h3B0:10'h3BB], [10'h3C0:10'h3DF]});
    pal = (l10 == 10'h3C6) || (l10 == 10'h3C8) || (l10 == 10'h3C9);
    alias_ok = !m_d16 || (a[15:10] == 6'd0);
    win = io ? (m_ioen && in_io) : (m_memen && (in_mem || in_pref));
    leg = m_vga && (io ? (m_ioen && vio && alias_ok) : (m_memen && fb));
    sp  = io ? m_ioen : m_memen;
    ev = v;
    ef = v && (sec ? (sp && !win && !leg) : (win || leg));
    es = v && !sec && io && m_ioen && m_pal && pal && alias_ok;
  endfunction

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (!rst_n) begin
      e_valid = 0; e_fwd = 0; e_snoop = 0; e_tag = "R1";
      m_iob = '0; m_iol = '0; m_mb = '0; m_ml = '0; m_pb = '0; m_pl = '0;
      m_ioen = 0; m_memen = 0; m_vga = 0; m_d16 = 0; m_pal = 0;
    end else begin
      predict(t_valid, t_sec, t_io, t_addr, e_valid, e_fwd, e_snoop);
      e_tag = t_valid ? cur_tag : "R1";
      m_iob = io_base; m_iol = io_limit; m_mb = mem_base; m_ml = mem_limit;
      m_pb = pref_base; m_pl = pref_limit;
      m_ioen = io_en; m_memen = mem_en; m_vga = vga_en; m_d16 = vga_dec16; m_pal = pal_snoop;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      n_cmp++;
      if ({valid_o, fwd_o, snoop_o} !== {e_valid, e_fwd, e_snoop}) begin
        n_bad++;
        $display("FAIL %s: valid/fwd/snoop got %b%b%b expected %b%b%b (addr %h sec %0d io %0d)",
                 e_tag, valid_o, fwd_o, snoop_o, e_valid, e_fwd, e_snoop, t_addr, t_sec, t_io);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > WATCHDOG && !done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      finish_run();
    end
  end

  task automatic txn(input bit sec, input bit io, input logic [63:0] a, input string tag);
    @(negedge clk);
    t_valid = 1; t_sec = sec; t_io = io; t_addr = a; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      t_valid = 0; t_sec = 0; t_io = 0;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    idle(2);
    // R1: hit-like address without valid stays quiet
    t_addr = 64'h100000;
    idle(2);

    mem_base = 44'h001; mem_limit = 44'h002;
    pref_base = 44'hFFF_FFFF_FFFF; pref_limit = 44'hFFF_FFFF_FFFF;
    io_base = 4'h1; io_limit = 4'h1;
    io_en = 1; mem_en = 1;
    idle(2);
    txn(0, 0, 64'h0010_0000, "R3");
    txn(0, 0, 64'h002F_FFFF, "R3");
    txn(0, 0, 64'h0030_0000, "R3");
    txn(0, 0, 64'h000F_FFFF, "R3");
    txn(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
    txn(0, 0, 64'hFFFF_FFFF_FFF0_0000, "R3");
    txn(1, 0, 64'h0030_0000, "R7");
    txn(1, 0, 64'h0015_0000, "R7");
    txn(1, 0, 64'hFFFF_FFFF_FFFF_FFF0, "R7");
    txn(0, 1, 64'h1000, "R4");
    txn(0, 1, 64'h1FFF, "R4");
    txn(0, 1, 64'h2000, "R4");
    txn(0, 1, 64'h0FFF, "R4");
    txn(0, 1, 64'h1_0000_1800, "R4");
    txn(1, 1, 64'h2000, "R7");
    txn(1, 1, 64'h1800, "R7");
    txn(0, 0, 64'h0020_0000, "R6");
    // config change in the same cycle as a hit: old setting decides
    txn(0, 0, 64'h0010_0000, "R2");
    mem_en = 0;
    txn(0, 0, 64'h0010_0000, "R2");
    txn(0, 0, 64'h0010_0000, "R5");
    txn(1, 0, 64'h0050_0000, "R5");
    mem_en = 1; io_en = 0;
    txn(0, 1, 64'h1000, "R2");
    txn(0, 1, 64'h1000, "R5");
    txn(1, 1, 64'h3000, "R5");
    io_en = 1;
    idle(1);

    // empty window
    mem_base = 44'h005; mem_limit = 44'h004;
    idle(1);
    txn(0, 0, 64'h0040_0000, "R3");
    txn(0, 0, 64'h0050_0000, "R3");
    txn(1, 0, 64'h0050_0000, "R3");

    // legacy display ranges
    vga_en = 1;
    idle(1);
    txn(0, 0, 64'hA0000, "R8");
    txn(0, 0, 64'hBFFFF, "R8");
    txn(0, 0, 64'hC0000, "R8");
    txn(0, 0, 64'h9FFFF, "R8");
    txn(1, 0, 64'hA8000, "R7");
    txn(1, 0, 64'hC0000, "R7");
    txn(0, 1, 64'h3B0, "R9");
    txn(0, 1, 64'h3BB, "R9");
    txn(0, 1, 64'h3BC, "R9");
    txn(0, 1, 64'h3BF, "R9");
    txn(0, 1, 64'h3C0, "R9");
    txn(0, 1, 64'h3DF, "R9");
    txn(0, 1, 64'h3E0, "R9");
    txn(0, 1, 64'hC3C0, "R9");
    txn(0, 1, 64'hFFB5, "R9");
    txn(1, 1, 64'h3C0, "R7");
    txn(1, 1, 64'h3BC, "R7");
    vga_dec16 = 1;
    idle(1);
    txn(0, 1, 64'hC3C0, "R10");
    txn(0, 1, 64'h03C0, "R10");
    txn(1, 1, 64'hC3C0, "R10");
    txn(0, 1, 64'h07B4, "R10");
    vga_dec16 = 0;
    vga_en = 0;
    idle(1);
    txn(0, 0, 64'hA0000, "R8");
    txn(1, 0, 64'hA0000, "R8");
    txn(0, 1, 64'h3C0, "R9");

    // palette snoop
    pal_snoop = 1;
    idle(1);
    txn(0, 1, 64'h3C6, "R11");
    txn(0, 1, 64'h3C7, "R11");
    txn(0, 1, 64'h83C9, "R11");
    txn(1, 1, 64'h3C6, "R11");
    txn(0, 0, 64'h3C6, "R11");
    vga_en = 1;
    idle(1);
    txn(0, 1, 64'h3C8, "R11");
    txn(0, 1, 64'h3C9, "R11");
    vga_dec16 = 1;
    idle(1);
    txn(0, 1, 64'h83C9, "R11");
    txn(0, 1, 64'h03C6, "R11");
    io_en = 0;
    idle(1);
    txn(0, 1, 64'h03C6, "R5");
    io_en = 1; vga_dec16 = 0;

    // overlap: memory window and frame buffer both claim
    mem_base = 44'h000; mem_limit = 44'h000;
    io_base = 4'h0; io_limit = 4'h0;
    idle(1);
    txn(0, 0, 64'hA0000, "R12");
    txn(1, 0, 64'hA0000, "R12");
    txn(0, 1, 64'h3C0, "R12");
    txn(0, 0, 64'h0000_1234, "R12");
    txn(1, 0, 64'h0010_0000, "R12");
    idle(3);
    finish_run();
  end
endmodule